// File: doc/BRIEF.md
# Protected Sector-Erase Flash Array Model

This block is a synthesizable behavioural model of a word-addressed, non-volatile array that follows the rules of NOR-type Flash. A command port accepts two operations: a word program and a sector erase. A separate port reads the array without waiting. A program can only pull bits low, because the stored word becomes the old word ANDed with the new data. Only an erase can bring bits back to one, and an erase always covers a whole sector.

The lowest sectors of the array hold operating-system code. Any program or erase aimed at them is refused and reported with a protection error code. An abort input models power loss or interruption. It stops the running operation at once, and it tags the sector that was being changed as corrupted. The tag stays until an erase of that sector runs to completion. The read port returns the stored word and the corruption tag of the sector it lies in.

At full size the block uses 32K-word sectors and a protected range of 0x0000 to 0x7FFF. Those sizes are set by parameters. The default configuration is scaled down (1024 words, four sectors of 256 words, the lowest sector protected) so that it stays small in simulation.

Top module: `flash_sector_emu`

## Requirements
- R1: After reset every word reads all ones, no sector reads as corrupted, busy and done are low, and status is 0 (OK).
- R2: A program command (cmd_op = 2'b01) to an unprotected address stores old AND cmd_data. Busy is high for exactly one cycle after acceptance, and done pulses for one cycle when busy falls.
- R3: Programming all ones to a word leaves the word unchanged.
- R4: An erase command (cmd_op = 2'b10) aligns its address down to the sector boundary. It sets every word of that sector to all ones, one word per cycle, and holds busy for exactly SECTOR_WORDS cycles before done pulses. Words in other sectors do not change.
- R5: A program or erase whose address lies in the protected low sectors (the default: addresses 0 to 255) changes no word and never raises busy. In the cycle after the command, done pulses and status reads 1 (protection error).
- R6: While busy, new commands are ignored. A command with cmd_op 2'b00 or 2'b11 is ignored at any time and leaves status unchanged.
- R7: When abort is high while busy, busy and done are both low on the next cycle, status reads 2 (abort error), and the affected sector reads as corrupted. When abort is high while idle, it has no effect.
- R8: The status code holds until the next accepted command, which overwrites it. A completed erase clears the corruption tag of its sector.
- R9: Reads during an operation return the current contents of the array: one cycle into an erase, the first word of the sector already reads all ones and the next word still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled when idle |
| cmd_op | input | 2 | 01 program, 10 erase, others ignored |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_data | input | DATA_W | Program data |
| abort | input | 1 | Interrupts a running operation |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Current word at rd_addr |
| rd_corrupt | output | 1 | Sector of rd_addr was hit by an abort |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion or rejection pulse |
| status | output | 2 | 0 OK, 1 protection error, 2 abort error |

## Verification
The hardest situation to reach is an erase that is stopped part way through its sweep. The bench first fills a sector with nonzero patterns, then starts the erase and raises abort on a chosen cycle while busy is still high. It checks that busy, done, status and the corruption tag respond on the next cycle, and that a later full erase clears the tag. Reads taken during the sweep, at the first and second cycles, show the erase front moving through the sector. An exhaustive read-back of all words after each phase confirms that no word outside the targeted sector has changed.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_RSVD  = 2'b11
   } flash_op_e;

   typedef enum logic [1:0] {
      STAT_OK    = 2'd0,
      STAT_PROT  = 2'd1,
      STAT_ABORT = 2'd2
   } flash_stat_e;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_PROG  = 2'd1,
      FS_ERASE = 2'd2
   } flash_fsm_e;
endpackage

// File: rtl/flash_word_array.sv
module flash_word_array #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_erase,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   // Program can only clear bits; erase restores all ones.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         if (wr_erase) cells[wr_addr] <= '1;
         else          cells[wr_addr] <= cells[wr_addr] & wr_data;
      end
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_sector_tags.sv
module flash_sector_tags #(
   parameter int NUM_SEC   = 4,
   parameter int SEC_IDX_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tag_set,
   input  logic                 tag_clr,
   input  logic [SEC_IDX_W-1:0] tag_sec,
   input  logic [SEC_IDX_W-1:0] rd_sec,
   output logic                 rd_tag
);
   logic [NUM_SEC-1:0] tags;

   for (genvar s = 0; s < NUM_SEC; s++) begin : g_tag
      always_ff @(posedge clk) begin
         if (!rst_n)
            tags[s] <= 1'b0;
         else if (tag_set && (tag_sec == SEC_IDX_W'(s)))
            tags[s] <= 1'b1;
         else if (tag_clr && (tag_sec == SEC_IDX_W'(s)))
            tags[s] <= 1'b0;
      end
   end

   assign rd_tag = tags[rd_sec];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_emu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 10,
   parameter int SECTOR_W     = 8,
   parameter int PROT_SECTORS = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [1:0]                 cmd_op,
   input  logic [ADDR_W-1:0]          cmd_addr,
   input  logic [DATA_W-1:0]          cmd_data,
   input  logic                       abort,
   output logic                       busy,
   output logic                       done,
   output logic [1:0]                 status,
   output logic                       wr_en,
   output logic                       wr_erase,
   output logic [ADDR_W-1:0]          wr_addr,
   output logic [DATA_W-1:0]          wr_data,
   output logic                       tag_set,
   output logic                       tag_clr,
   output logic [ADDR_W-SECTOR_W-1:0] tag_sec
);
   localparam int SEC_IDX_W = ADDR_W - SECTOR_W;
   localparam logic [SEC_IDX_W:0] PROT_LIM = (SEC_IDX_W+1)'(PROT_SECTORS);

   flash_fsm_e          state_q;
   logic [ADDR_W-1:0]   op_addr_q;
   logic [DATA_W-1:0]   op_data_q;
   logic                done_q;
   flash_stat_e         status_q;

   logic [SEC_IDX_W-1:0] cmd_sec;
   logic                 cmd_in_prot;
   logic                 cmd_is_prog;
   logic                 cmd_is_erase;
   logic                 cmd_take;
   logic                 sweep_last;

   assign cmd_sec      = cmd_addr[ADDR_W-1:SECTOR_W];
   assign cmd_in_prot  = ({1'b0, cmd_sec} < PROT_LIM);
   assign cmd_is_prog  = (cmd_op == OP_PROG);
   assign cmd_is_erase = (cmd_op == OP_ERASE);
   assign cmd_take     = cmd_valid && (state_q == FS_IDLE) && (cmd_is_prog || cmd_is_erase);
   assign sweep_last   = &op_addr_q[SECTOR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= FS_IDLE;
         op_addr_q <= '0;
         op_data_q <= '0;
         done_q    <= 1'b0;
         status_q  <= STAT_OK;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: begin
               if (cmd_take) begin
                  if (cmd_in_prot) begin
                     status_q <= STAT_PROT;
                     done_q   <= 1'b1;
                  end else begin
                     status_q  <= STAT_OK;
                     op_data_q <= cmd_data;
                     if (cmd_is_erase) begin
                        op_addr_q <= {cmd_sec, {SECTOR_W{1'b0}}};
                        state_q   <= FS_ERASE;
                     end else begin
                        op_addr_q <= cmd_addr;
                        state_q   <= FS_PROG;
                     end
                  end
               end
            end
            FS_PROG: begin
               state_q <= FS_IDLE;
               if (abort) status_q <= STAT_ABORT;
               else       done_q   <= 1'b1;
            end
            FS_ERASE: begin
               if (abort) begin
                  status_q <= STAT_ABORT;
                  state_q  <= FS_IDLE;
               end else if (sweep_last) begin
                  done_q  <= 1'b1;
                  state_q <= FS_IDLE;
               end else begin
                  op_addr_q <= op_addr_q + 1'b1;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != FS_IDLE);
   assign done     = done_q;
   assign status   = status_q;
   assign wr_en    = busy && !abort;
   assign wr_erase = (state_q == FS_ERASE);
   assign wr_addr  = op_addr_q;
   assign wr_data  = op_data_q;
   assign tag_set  = busy && abort;
   assign tag_clr  = (state_q == FS_ERASE) && !abort && sweep_last;
   assign tag_sec  = op_addr_q[ADDR_W-1:SECTOR_W];
endmodule

// File: rtl/flash_sector_emu.sv
module flash_sector_emu #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 10,
   parameter int SECTOR_W     = 8,
   parameter int PROT_SECTORS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              abort,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_corrupt,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status
);
   localparam int SEC_IDX_W = ADDR_W - SECTOR_W;
   localparam int NUM_SEC   = 1 << SEC_IDX_W;

   if (DATA_W < 1)
      $error("flash_sector_emu: DATA_W must be positive");
   if (SECTOR_W < 1 || SECTOR_W >= ADDR_W)
      $error("flash_sector_emu: SECTOR_W must lie in 1..ADDR_W-1");
   if (PROT_SECTORS < 0 || PROT_SECTORS >= NUM_SEC)
      $error("flash_sector_emu: PROT_SECTORS must leave an open sector");

   logic                 wr_en, wr_erase, tag_set, tag_clr;
   logic [ADDR_W-1:0]    wr_addr;
   logic [DATA_W-1:0]    wr_data;
   logic [SEC_IDX_W-1:0] tag_sec;

   flash_cmd_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SECTOR_W(SECTOR_W), .PROT_SECTORS(PROT_SECTORS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .abort(abort),
      .busy(busy), .done(done), .status(status),
      .wr_en(wr_en), .wr_erase(wr_erase), .wr_addr(wr_addr), .wr_data(wr_data),
      .tag_set(tag_set), .tag_clr(tag_clr), .tag_sec(tag_sec)
   );

   flash_word_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_erase(wr_erase), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   flash_sector_tags #(.NUM_SEC(NUM_SEC), .SEC_IDX_W(SEC_IDX_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .tag_set(tag_set), .tag_clr(tag_clr), .tag_sec(tag_sec),
      .rd_sec(rd_addr[ADDR_W-1:SECTOR_W]), .rd_tag(rd_corrupt)
   );
endmodule

// File: rtl/flash_sector_emu_chk.sv
module flash_sector_emu_chk #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 10,
   parameter int SECTOR_W     = 8,
   parameter int PROT_SECTORS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              abort,
   input logic              busy,
   input logic              done,
   input logic [1:0]        status
);
   localparam int SEC_IDX_W = ADDR_W - SECTOR_W;
   localparam logic [SEC_IDX_W:0] LIM = (SEC_IDX_W+1)'(PROT_SECTORS);

   logic valid_op, in_prot;
   assign valid_op = (cmd_op == 2'b01) || (cmd_op == 2'b10);
   assign in_prot  = ({1'b0, cmd_addr[ADDR_W-1:SECTOR_W]} < LIM);

   assert_prot_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && valid_op && in_prot) |=> (done && !busy && status == 2'd1));

   assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op == 2'b01 && !in_prot) |=> busy);

   assert_abort_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> (!busy && !done && status == 2'd2));

   assert_idle_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && abort && !cmd_valid) |=> $stable(status));

   assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !abort) |=> (busy || done));

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_bad_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !abort && !(cmd_valid && valid_op)) |=> ($stable(status) && !busy && !done));
endmodule

bind flash_sector_emu flash_sector_emu_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .SECTOR_W(SECTOR_W), .PROT_SECTORS(PROT_SECTORS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_addr(cmd_addr), .abort(abort), .busy(busy), .done(done), .status(status)
);

// File: tb/sim_flash_sector_emu.sv
`timescale 1ns/1ps
module sim_flash_sector_emu;
   localparam int DW = 16, AW = 10, SW = 8, PS = 1;
   localparam int DEPTH = 1 << AW, SECW = 1 << SW, NSEC = 1 << (AW - SW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, abort = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
   logic [DW-1:0] cmd_data = '0, rd_data;
   logic rd_corrupt, busy, done;
   logic [1:0] status;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] model [DEPTH];
   logic unk [NSEC];

   always #4 clk = ~clk;

   flash_sector_emu #(.DATA_W(DW), .ADDR_W(AW), .SECTOR_W(SW), .PROT_SECTORS(PS)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .abort(abort),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_corrupt(rd_corrupt),
      .busy(busy), .done(done), .status(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = AW'(a);
         #0.1;
         chk({req, " corrupt"}, 32'(rd_corrupt), 32'(unk[a / SECW]));
         if (!unk[a / SECW]) chk({req, " word"}, 32'(rd_data), 32'(model[a]));
      end
   endtask

   task automatic issue(input logic [1:0] op, input int addr, input logic [DW-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic prog(input int addr, input logic [DW-1:0] d, input string req);
      issue(2'b01, addr, d);
      chk({req, " busy"}, 32'(busy), 32'd1);
      @(negedge clk);
      chk({req, " done"}, {30'd0, busy, done}, 32'd1);
      chk({req, " status"}, 32'(status), 32'd0);
      model[addr] = model[addr] & d;
   endtask

   task automatic erase(input int addr, input string req);
      int cnt;
      issue(2'b10, addr, '0);
      cnt = 0;
      while (busy && cnt < 4 * SECW) begin cnt++; @(negedge clk); end
      chk({req, " busy cycles"}, 32'(cnt), 32'(SECW));
      chk({req, " done"}, 32'(done), 32'd1);
      for (int a = (addr / SECW) * SECW; a < (addr / SECW + 1) * SECW; a++) model[a] = '1;
      unk[addr / SECW] = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) model[a] = '1;
      for (int s = 0; s < NSEC; s++) unk[s] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy/done/status", {28'd0, busy, done, status}, 32'd0);
      sweep("R1");

      // R2: program patterns across unprotected sectors
      for (int a = SECW; a < DEPTH; a += 3)
         prog(a, DW'(~(32'h1 << (a % DW)) ^ (a * 32'h0101 & 32'h00F0)), "R2 pat1");
      for (int a = SECW; a < DEPTH; a += 6)
         prog(a, DW'(a * 32'h9E37), "R2 pat2 AND");
      sweep("R2");

      // R3: all-ones program leaves words unchanged
      for (int a = SECW + 1; a < DEPTH; a += 37) prog(a, '1, "R3");
      sweep("R3");

      // R5: protected region refused
      issue(2'b01, 5, 16'h0000);
      chk("R5 prog done/busy", {30'd0, busy, done}, 32'd1);
      chk("R5 prog status", 32'(status), 32'd1);
      issue(2'b10, SECW - 1, '0);
      chk("R5 erase done/busy", {30'd0, busy, done}, 32'd1);
      chk("R5 erase status", 32'(status), 32'd1);
      @(negedge clk);
      chk("R8 status held", 32'(status), 32'd1);
      chk("R5 no busy", 32'(busy), 32'd0);
      sweep("R5");

      // R6: reserved op codes ignored
      issue(2'b11, SECW + 3, 16'h0000);
      chk("R6 rsvd busy/done", {30'd0, busy, done}, 32'd0);
      chk("R6 rsvd status", 32'(status), 32'd1);
      issue(2'b00, SECW + 3, 16'h0000);
      chk("R6 none busy/done", {30'd0, busy, done}, 32'd0);

      // R4 + R9: erase sector 2 from unaligned address, reads mid-sweep
      model[2 * SECW + 1] = model[2 * SECW + 1] & 16'h0F0F;
      prog(2 * SECW + 1, 16'h0F0F, "R4 setup");
      prog(2 * SECW, 16'h1234, "R4 setup");
      issue(2'b10, 2 * SECW + 77, '0);
      chk("R8 status cleared", 32'(status), 32'd0);
      rd_addr = AW'(2 * SECW); #0.1;
      chk("R9 base before", 32'(rd_data), 32'(model[2 * SECW]));
      @(negedge clk);
      rd_addr = AW'(2 * SECW); #0.1;
      chk("R9 base swept", 32'(rd_data), 32'hFFFF);
      rd_addr = AW'(2 * SECW + 1); #0.1;
      chk("R9 next pending", 32'(rd_data), 32'(model[2 * SECW + 1]));
      // R6: command while busy is ignored
      issue(2'b01, SECW + 4, 16'h0000);
      begin
         int cnt = 3;
         while (busy && cnt < 4 * SECW) begin cnt++; @(negedge clk); end
         chk("R4 busy cycles", 32'(cnt), 32'(SECW));
      end
      chk("R4 done", 32'(done), 32'd1);
      @(negedge clk);
      chk("R4 done pulse", 32'(done), 32'd0);
      for (int a = 2 * SECW; a < 3 * SECW; a++) model[a] = '1;
      sweep("R4/R6");

      // R7: abort during erase of sector 3
      prog(3 * SECW + 9, 16'h0000, "R7 setup");
      issue(2'b10, 3 * SECW, '0);
      repeat (5) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R7 erase abort", {28'd0, busy, done, status}, 32'd2);
      unk[3] = 1'b1;
      rd_addr = AW'(3 * SECW + 9); #0.1;
      chk("R7 corrupt tag", 32'(rd_corrupt), 32'd1);
      // R7: abort while idle has no effect
      abort = 1'b1; repeat (2) @(negedge clk); abort = 1'b0;
      chk("R7 idle abort", {28'd0, busy, done, status}, 32'd2);
      sweep("R7");

      // R7: abort during program of sector 1
      issue(2'b01, SECW + 2, 16'h0000);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R7 prog abort", {28'd0, busy, done, status}, 32'd2);
      unk[1] = 1'b1;
      sweep("R7 prog");

      // R8: full erase clears tags
      erase(3 * SECW + 100, "R8 s3");
      erase(SECW, "R8 s1");
      chk("R8 status", 32'(status), 32'd0);
      sweep("R8");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule